// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and reports their ordering on three flags: greater, less and equal. It is built from 4-bit comparison stages. Each stage examines its bit pairs from the most significant down, and the first pair that differs decides the result. When all of a stage's bit pairs match, the stage passes on the ordering it receives on its three tie-break inputs.

The top module chains enough stages to cover a `WIDTH`-bit operand. The least significant stage comes first, and each stage's flags feed the tie-break inputs of the next stage up. Bits above `WIDTH` in the last stage are filled with zero.

The chain's own tie-break inputs feed the lowest stage. They are normally driven as equal=1, greater=0, less=0. Another comparator can also drive them, so that several chains cover an even wider word. The block is purely combinational and holds no state.

Top module: `mag_cmp_chain`

## Requirements
- R1: When the most significant bit pair of the operands differs, `gt_o`/`lt_o` follow that pair (`a` bit high gives `gt_o`=1), whatever the lower bits and tie-break inputs are.
- R2: When all higher bit pairs match, the highest differing pair at any position decides the result; lower bits and tie-break inputs have no effect.
- R3: When `a` equals `b`, the outputs `{gt_o,lt_o,eq_o}` equal `{tie_gt_i,tie_lt_i,tie_eq_i}` for all eight input combinations, including the illegal ones.
- R4: With exactly one tie-break input high, exactly one output is high.
- R5: With tie-break inputs equal=1, greater=0, less=0, the outputs match a direct `WIDTH`-bit unsigned compare for any operands, including cases where a lower stage and a higher stage disagree.
- R6: Operands holding packed decimal digits (4 bits per digit, values 0 to 9) are ordered by their decimal value.
- R7: The outputs depend only on the present inputs: the same inputs give the same outputs whatever was applied before, and no clock edge is needed for them to settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| tie_gt_i | input | 1 | Tie-break input: lower-order result is greater |
| tie_lt_i | input | 1 | Tie-break input: lower-order result is less |
| tie_eq_i | input | 1 | Tie-break input: lower-order result is equal |
| gt_o | output | 1 | A greater than B |
| lt_o | output | 1 | A less than B |
| eq_o | output | 1 | A equal to B (or tie-break passed through) |

## Verification
Two functions can be active for the same inputs: a lower stage settling a tie and a higher stage overruling it with its own differing bits. The bench provokes this in two ways. It uses operands whose low digit orders one way and whose high digit orders the other way, and it drives the tie-break inputs opposite to the true answer while upper bits differ. It judges the result only by the most significant differing bit. A separate sweep over equal operands covers all eight tie-break combinations, to confirm that pass-through alone decides when no bit differs.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

  localparam rel_t REL_GT = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
  localparam rel_t REL_LT = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
endpackage

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import mag_cmp_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  rel_t               tie_i,
  output rel_t               rel_o
);
  localparam int TOP = DIGIT_W - 1;

  logic [DIGIT_W-1:0] pair_gt;
  logic [DIGIT_W-1:0] pair_lt;

  for (genvar g = 0; g < DIGIT_W; g++) begin : g_pair
    assign pair_gt[g] = a_i[g] & ~b_i[g];
    assign pair_lt[g] = ~a_i[g] & b_i[g];
  end

  // Walk upward so that a higher differing pair overrides a lower one.
  rel_t res;
  always_comb begin
    res = tie_i;
    for (int i = 0; i < DIGIT_W; i++) begin
      if (pair_gt[i])      res = REL_GT;
      else if (pair_lt[i]) res = REL_LT;
    end
  end

  assign rel_o = res;

  always_comb begin
    if (a_i[TOP] != b_i[TOP]) begin
      p_msb_decides_r1: assert (rel_o.gt == a_i[TOP] && rel_o.lt == b_i[TOP])
        else $error("stage: top pair did not decide");
    end
    if (DIGIT_W > 1) begin
      if (a_i[TOP] == b_i[TOP] && a_i[TOP-1] != b_i[TOP-1]) begin
        p_next_pair_r2: assert (rel_o.gt == a_i[TOP-1] && rel_o.lt == b_i[TOP-1])
          else $error("stage: second pair did not decide");
      end
    end
    if (a_i == b_i) begin
      p_tie_pass_r3: assert (rel_o == tie_i)
        else $error("stage: tie-break not passed through");
    end
    if ($onehot(tie_i)) begin
      p_onehot_out_r4: assert ($onehot(rel_o))
        else $error("stage: outputs not one-hot");
    end
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH   = 10,
  parameter int DIGIT_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             tie_gt_i,
  input  logic             tie_lt_i,
  input  logic             tie_eq_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  localparam int NSTAGE = (WIDTH + DIGIT_W - 1) / DIGIT_W;
  localparam int PADW   = NSTAGE * DIGIT_W;

  logic [PADW-1:0] a_pad;
  logic [PADW-1:0] b_pad;

  always_comb begin
    a_pad = '0;
    b_pad = '0;
    a_pad[WIDTH-1:0] = a_i;
    b_pad[WIDTH-1:0] = b_i;
  end

  rel_t link [NSTAGE+1];

  assign link[0] = '{gt: tie_gt_i, lt: tie_lt_i, eq: tie_eq_i};

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    mag_cmp_stage #(.DIGIT_W(DIGIT_W)) i_stage (
      .a_i   (a_pad[s*DIGIT_W +: DIGIT_W]),
      .b_i   (b_pad[s*DIGIT_W +: DIGIT_W]),
      .tie_i (link[s]),
      .rel_o (link[s+1])
    );
  end

  assign gt_o = link[NSTAGE].gt;
  assign lt_o = link[NSTAGE].lt;
  assign eq_o = link[NSTAGE].eq;
endmodule

// File: tb/test_mag_cmp_chain.sv
module test_mag_cmp_chain;
  localparam int W = 10;

  logic clk;
  logic [W-1:0] a, b;
  logic tgt, tlt, teq;
  logic gt, lt, eq;
  int errors = 0;
  int checks = 0;

  mag_cmp_chain #(.WIDTH(W)) i_mag_cmp_chain (
    .a_i(a), .b_i(b), .tie_gt_i(tgt), .tie_lt_i(tlt), .tie_eq_i(teq),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [2:0] model(int ua, int ub, logic [2:0] t);
    if (ua > ub) return 3'b100;
    if (ua < ub) return 3'b010;
    return t;
  endfunction

  task automatic apply(input int ua, input int ub, input logic [2:0] t);
    @(negedge clk);
    a = W'(ua); b = W'(ub); {tgt, tlt, teq} = t;
    #2;
  endtask

  task automatic expect_rel(input string req, input logic [2:0] exp);
    checks++;
    if ({gt, lt, eq} !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d tie=%b: got %b expected %b",
               req, a, b, {tgt, tlt, teq}, {gt, lt, eq}, exp);
    end
  endtask

  task automatic t_idle_r3;
    apply(0, 0, 3'b001);
    expect_rel("R3 idle", 3'b001);
  endtask

  task automatic t_msb_r1;
    apply(10'h200, 10'h1FF, 3'b010);
    expect_rel("R1", 3'b100);
    apply(10'h1FF, 10'h200, 3'b100);
    expect_rel("R1", 3'b010);
    apply(10'h3FF, 10'h0FF, 3'b111);
    expect_rel("R1", 3'b100);
  endtask

  task automatic t_each_pos_r2;
    for (int i = 0; i < W; i++) begin
      int hi = (10'h2A5 >> (i + 1)) << (i + 1);
      int ua = hi | (1 << i);
      int ub = hi | ((1 << i) - 1);
      apply(ua, ub, 3'b010);
      expect_rel("R2", 3'b100);
      apply(ub, ua, 3'b100);
      expect_rel("R2", 3'b010);
    end
  endtask

  task automatic t_tie_r3;
    for (int c = 0; c < 8; c++) begin
      int v = (c * 97 + 13) % 1024;
      apply(v, v, 3'(c));
      expect_rel("R3", 3'(c));
    end
  endtask

  task automatic t_onehot_r4;
    for (int k = 0; k < 60; k++) begin
      int ua = int'($urandom_range(1023));
      int ub = (k % 3 == 0) ? ua : int'($urandom_range(1023));
      logic [2:0] t = 3'b001 << (k % 3);
      apply(ua, ub, t);
      checks++;
      if ($countones({gt, lt, eq}) != 1) begin
        errors++;
        $display("FAIL R4 got %b expected one-hot", {gt, lt, eq});
      end
    end
  endtask

  task automatic t_random_r5;
    for (int k = 0; k < 300; k++) begin
      int ua = int'($urandom_range(1023));
      int ub = int'($urandom_range(1023));
      apply(ua, ub, 3'b001);
      expect_rel("R5", model(ua, ub, 3'b001));
    end
  endtask

  task automatic t_stage_clash_r5;
    apply(10'h10F, 10'h120, 3'b001);
    expect_rel("R5 clash", 3'b010);
    apply(10'h230, 10'h12F, 3'b001);
    expect_rel("R5 clash", 3'b100);
    apply(10'h1FF, 10'h200, 3'b100);
    expect_rel("R5 clash", 3'b010);
  endtask

  task automatic t_bcd_r6;
    for (int x = 0; x < 100; x += 3) begin
      for (int y = 0; y < 100; y += 7) begin
        int px = ((x / 10) << 4) | (x % 10);
        int py = ((y / 10) << 4) | (y % 10);
        apply(px, py, 3'b001);
        expect_rel("R6", model(x, y, 3'b001));
      end
    end
  endtask

  task automatic t_nostate_r7;
    apply(1023, 0, 3'b001);
    apply(0, 1023, 3'b100);
    apply(300, 300, 3'b001);
    expect_rel("R7", 3'b001);
    @(negedge clk);
    #1;
    a = W'(301);
    #1;
    expect_rel("R7 no edge", 3'b100);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; tgt = 1'b0; tlt = 1'b0; teq = 1'b1;
    t_idle_r3();
    t_msb_r1();
    t_each_pos_r2();
    t_tie_r3();
    t_onehot_r4();
    t_random_r5();
    t_stage_clash_r5();
    t_bcd_r6();
    t_nostate_r7();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule